// File: doc/BRIEF.md
# Multi-Mode Programmable Logic Cell

This block is one logic cell of a programmable fabric. Four data bits, a carry input and a cascade input feed it. A small set of static configuration inputs gives it one of three personalities. In the lookup personality a single 4-input table drives the output. In the arithmetic personality the 16-bit table splits into two 3-input halves: one half gives the function or sum bit and the other half gives the carry to the next cell. In the counter personality the cell register becomes one bit of a synchronous up/down counter, and the carry input and carry output link neighbouring bits.

In every personality the cell drives an unregistered output and a registered output. It also drives a cascade output, which is the AND of its own output and the cascade input, so that a row of cells can form a wide AND-based decoder. Synchronous clear, synchronous load and clock enable act on the register in every personality. In normal mode the register can also be packed: it samples a data bit directly while the table result is used only combinationally.

Top module: `fab_cell`

## Requirements
- R1: With cfgMode 0 or 3 (normal) and cfgUseCin=0, combOut equals cfgMask[{dataIn[3],dataIn[2],dataIn[1],dataIn[0]}], and carryOut is 0.
- R2: In normal mode with cfgUseCin=1, carryIn replaces dataIn[3] as the most significant table index bit.
- R3: In every mode, cascOut equals combOut AND cascIn.
- R4: With cfgMode 1 (arithmetic), combOut equals cfgMask[{carryIn,dataIn[1],dataIn[0]}] (index 0..7) and carryOut equals cfgMask[8+{carryIn,dataIn[1],dataIn[0]}].
- R5: In normal mode (cfgPack=0) and in arithmetic mode, a clock edge with clkEn=1, sClr=0 and sLoad=0 loads regOut with the combOut value from before the edge. combOut and regOut are driven at the same time.
- R6: In normal mode with cfgPack=1, the register captures dataIn[3] while combOut still shows the table result.
- R7: With cfgMode 2 (counter), dataIn[0] is the count enable and dataIn[1] selects up (1) or down (0). The bit toggles on an edge only when the count enable and carryIn are both 1, and combOut equals regOut.
- R8: In counter mode, carryOut equals regOut AND carryIn when counting up, and NOT regOut AND carryIn when counting down.
- R9: With clkEn=1, sClr forces regOut to 0 ahead of sLoad. Otherwise sLoad loads dataIn[2] ahead of the mode's own update. Both act in every mode.
- R10: With clkEn=0, regOut holds through the edge, whatever sClr, sLoad and the data inputs are.
- R11: rstN low clears regOut at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock |
| rstN | input | 1 | Asynchronous active-low register reset |
| cfgMode | input | 2 | 0 normal, 1 arithmetic, 2 counter, 3 normal |
| cfgMask | input | 16 | Lookup table contents |
| cfgUseCin | input | 1 | Normal mode: carryIn replaces dataIn[3] in the table index |
| cfgPack | input | 1 | Normal mode: register samples dataIn[3] directly |
| dataIn | input | 4 | Data inputs from local routing |
| carryIn | input | 1 | Carry chain input |
| cascIn | input | 1 | Cascade chain input (tie high when unused) |
| clkEn | input | 1 | Register clock enable |
| sClr | input | 1 | Shared synchronous clear |
| sLoad | input | 1 | Shared synchronous load of dataIn[2] |
| combOut | output | 1 | Unregistered cell output |
| regOut | output | 1 | Registered cell output |
| carryOut | output | 1 | Carry chain output |
| cascOut | output | 1 | Cascade chain output |

## Verification
The cell's only internal state is its register bit. A wrong bit shows on regOut one edge after the faulty update. In counter mode it shows in the same cycle on combOut, on cascOut and on the direction-dependent carryOut, because all three are derived from the stored bit. A wrong mode or index decode is purely combinational, so it shows on combOut and carryOut as soon as the inputs settle, with no clock needed. The bench therefore samples combinational results in the middle of the low clock phase and register results shortly after each rising edge.

// File: rtl/fab_cell_pkg.sv
`timescale 1ns/1ps
package fab_cell_pkg;

  typedef enum logic [1:0] {
    MODE_LUT   = 2'd0,
    MODE_ARITH = 2'd1,
    MODE_COUNT = 2'd2,
    MODE_ALT   = 2'd3
  } cellMode_t;

  typedef enum logic [2:0] {
    SRC_HOLD   = 3'd0,
    SRC_ZERO   = 3'd1,
    SRC_LOAD   = 3'd2,
    SRC_FUNC   = 3'd3,
    SRC_PACK   = 3'd4,
    SRC_TOGGLE = 3'd5
  } regSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    wrEn;
    regSrc_t src;
    logic    arith;
    logic    count;
    logic    cinToLut;
    logic    countUp;
  } cellCtl_t;

endpackage

// File: rtl/fab_lut_mux.sv
`timescale 1ns/1ps
// K-input lookup: binary mux tree stored as a heap (root at 1, leaves at N..2N-1)
module fab_lut_mux #(
  parameter int K = 4
) (
  input  logic [(1<<K)-1:0] mask,
  input  logic [K-1:0]      sel,
  output logic              y
);
  localparam int N = 1 << K;

  logic [2*N-1:1] node;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_leaf
      assign node[N+i] = mask[i];
    end
  endgenerate

  genvar lvl, k;
  generate
    for (lvl = 0; lvl < K; lvl++) begin : g_lvl
      for (k = 0; k < (1 << lvl); k++) begin : g_node
        localparam int J = (1 << lvl) + k;
        assign node[J] = sel[K-1-lvl] ? node[2*J+1] : node[2*J];
      end
    end
  endgenerate

  assign y = node[1];
endmodule

// File: rtl/fab_cell_ctrl.sv
`timescale 1ns/1ps
module fab_cell_ctrl
  import fab_cell_pkg::*;
(
  input  logic [1:0] cfgMode,
  input  logic       cfgUseCin,
  input  logic       cfgPack,
  input  logic       clkEn,
  input  logic       sClr,
  input  logic       sLoad,
  input  logic       cntEnBit,
  input  logic       upBit,
  input  logic       carryIn,
  output cellCtl_t   ctl
);
  cellMode_t mode;
  logic      isNormal;
  regSrc_t   src;

  assign mode     = cellMode_t'(cfgMode);
  assign isNormal = (mode == MODE_LUT) || (mode == MODE_ALT);

  // register source priority: clear, load, then the mode's own update
  always_comb begin
    if (sClr)
      src = SRC_ZERO;
    else if (sLoad)
      src = SRC_LOAD;
    else if (mode == MODE_COUNT)
      src = (cntEnBit && carryIn) ? SRC_TOGGLE : SRC_HOLD;
    else if (isNormal && cfgPack)
      src = SRC_PACK;
    else
      src = SRC_FUNC;
  end

  always_comb begin
    ctl          = '0;
    ctl.src      = src;
    ctl.wrEn     = clkEn && (src != SRC_HOLD);
    ctl.arith    = (mode == MODE_ARITH);
    ctl.count    = (mode == MODE_COUNT);
    ctl.cinToLut = isNormal && cfgUseCin;
    ctl.countUp  = upBit;
  end
endmodule

// File: rtl/fab_cell_dp.sv
`timescale 1ns/1ps
module fab_cell_dp
  import fab_cell_pkg::*;
#(
  parameter int K        = 4,
  parameter int LOAD_IDX = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  cellCtl_t         ctl,
  input  logic [(1<<K)-1:0] mask,
  input  logic [K-1:0]     dataIn,
  input  logic             carryIn,
  input  logic             cascIn,
  output logic             combOut,
  output logic             regOut,
  output logic             carryOut,
  output logic             cascOut
);
  localparam int FULL_W = 1 << K;
  localparam int HALF_W = FULL_W / 2;

  logic [K-1:0] fullIdx;
  logic [K-2:0] halfIdx;
  logic         fullOut, loOut, hiOut, funcOut;
  logic         q;

  assign fullIdx = {ctl.cinToLut ? carryIn : dataIn[K-1], dataIn[K-2:0]};
  assign halfIdx = {carryIn, dataIn[K-3:0]};

  fab_lut_mux #(.K(K)) uFull (
    .mask(mask), .sel(fullIdx), .y(fullOut)
  );
  fab_lut_mux #(.K(K-1)) uLo (
    .mask(mask[HALF_W-1:0]), .sel(halfIdx), .y(loOut)
  );
  fab_lut_mux #(.K(K-1)) uHi (
    .mask(mask[FULL_W-1:HALF_W]), .sel(halfIdx), .y(hiOut)
  );

  assign funcOut = ctl.arith ? loOut : fullOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      q <= 1'b0;
    else if (ctl.wrEn) begin
      unique case (ctl.src)
        SRC_ZERO:   q <= 1'b0;
        SRC_LOAD:   q <= dataIn[LOAD_IDX];
        SRC_FUNC:   q <= funcOut;
        SRC_PACK:   q <= dataIn[K-1];
        SRC_TOGGLE: q <= ~q;
        default:    q <= q;
      endcase
    end
  end

  always_comb begin
    if (ctl.count) begin
      combOut  = q;
      carryOut = (ctl.countUp ? q : ~q) & carryIn;
    end else begin
      combOut  = funcOut;
      carryOut = ctl.arith ? hiOut : 1'b0;
    end
  end

  assign regOut  = q;
  assign cascOut = combOut & cascIn;
endmodule

// File: rtl/fab_cell.sv
`timescale 1ns/1ps
module fab_cell
  import fab_cell_pkg::*;
#(
  parameter int LUT_K      = 4,
  parameter int LOAD_IDX   = 2,
  parameter int CNT_EN_IDX = 0,
  parameter int UP_IDX     = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            cfgMode,
  input  logic [(1<<LUT_K)-1:0] cfgMask,
  input  logic                  cfgUseCin,
  input  logic                  cfgPack,
  input  logic [LUT_K-1:0]      dataIn,
  input  logic                  carryIn,
  input  logic                  cascIn,
  input  logic                  clkEn,
  input  logic                  sClr,
  input  logic                  sLoad,
  output logic                  combOut,
  output logic                  regOut,
  output logic                  carryOut,
  output logic                  cascOut
);
  cellCtl_t ctl;

  fab_cell_ctrl uCtrl (
    .cfgMode  (cfgMode),
    .cfgUseCin(cfgUseCin),
    .cfgPack  (cfgPack),
    .clkEn    (clkEn),
    .sClr     (sClr),
    .sLoad    (sLoad),
    .cntEnBit (dataIn[CNT_EN_IDX]),
    .upBit    (dataIn[UP_IDX]),
    .carryIn  (carryIn),
    .ctl      (ctl)
  );

  fab_cell_dp #(.K(LUT_K), .LOAD_IDX(LOAD_IDX)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .mask    (cfgMask),
    .dataIn  (dataIn),
    .carryIn (carryIn),
    .cascIn  (cascIn),
    .combOut (combOut),
    .regOut  (regOut),
    .carryOut(carryOut),
    .cascOut (cascOut)
  );
endmodule

// File: rtl/fab_cell_chk.sv
`timescale 1ns/1ps
module fab_cell_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] cfgMode,
  input logic       cfgPack,
  input logic [3:0] dataIn,
  input logic       carryIn,
  input logic       cascIn,
  input logic       clkEn,
  input logic       sClr,
  input logic       sLoad,
  input logic       combOut,
  input logic       regOut,
  input logic       carryOut,
  input logic       cascOut
);
  logic packActive, plainUpd, countMode;
  assign countMode  = (cfgMode == 2'd2);
  assign packActive = cfgPack && (cfgMode == 2'd0 || cfgMode == 2'd3);
  assign plainUpd   = clkEn && !sClr && !sLoad;

  p_casc_r3: assert property (@(posedge clk) disable iff (!rstN)
    cascOut == (combOut & cascIn));

  p_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    (plainUpd && !countMode && !packActive) |=> regOut == $past(combOut));

  p_pack_r6: assert property (@(posedge clk) disable iff (!rstN)
    (plainUpd && packActive) |=> regOut == $past(dataIn[3]));

  p_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    (plainUpd && countMode) |=> regOut == ($past(regOut) ^ ($past(dataIn[0]) & $past(carryIn))));

  p_carry_r8: assert property (@(posedge clk) disable iff (!rstN)
    countMode |-> carryOut == ((dataIn[1] ? regOut : ~regOut) & carryIn));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && sClr) |=> !regOut);

  p_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !sClr && sLoad) |=> regOut == $past(dataIn[2]));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(regOut));
endmodule

bind fab_cell fab_cell_chk uChk (
  .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgPack(cfgPack),
  .dataIn(dataIn), .carryIn(carryIn), .cascIn(cascIn), .clkEn(clkEn),
  .sClr(sClr), .sLoad(sLoad), .combOut(combOut), .regOut(regOut),
  .carryOut(carryOut), .cascOut(cascOut)
);

// File: tb/sim_fab_cell.sv
`timescale 1ns/1ps
module sim_fab_cell;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] cfgMode = 2'd0;
  logic [15:0] cfgMask = 16'h0;
  logic       cfgUseCin = 1'b0, cfgPack = 1'b0;
  logic [3:0] dataIn = 4'h0;
  logic       carryIn = 1'b0, cascIn = 1'b1;
  logic       clkEn = 1'b0, sClr = 1'b0, sLoad = 1'b0;
  logic       combOut, regOut, carryOut, cascOut;

  int total = 0;
  int bad = 0;

  fab_cell u0 (.*);

  always #10 clk = ~clk;

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] mask;
    logic        useCin;
    logic [3:0]  data;
    logic        cin;
    logic        casc;
    logic        expComb;
    logic        expCarry;
    logic        expCasc;
  } vec_t;

  // 16'h6996: entry i = parity(i); 16'hE896: low half sum, high half majority
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'h6996, 1'b0, 4'b0111, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R1
    '{2'd0, 16'h6996, 1'b1, 4'b1000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R2
    '{2'd0, 16'h6996, 1'b1, 4'b0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 R3
    '{2'd3, 16'h8000, 1'b0, 4'b1111, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R1
    '{2'd3, 16'h8000, 1'b0, 4'b1110, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R1
    '{2'd1, 16'hE896, 1'b0, 4'b1100, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R4
    '{2'd1, 16'hE896, 1'b0, 4'b0011, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R4
    '{2'd1, 16'hE896, 1'b0, 4'b0010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 R3
    '{2'd1, 16'hFF00, 1'b0, 4'b0011, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}  // R4
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic edgeThen;
    @(posedge clk);
    #5;
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #5;
    chk("R11 reset regOut", regOut, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    // combinational table walk, register held
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cfgMode = VECS[i].mode; cfgMask = VECS[i].mask; cfgUseCin = VECS[i].useCin;
      dataIn = VECS[i].data; carryIn = VECS[i].cin; cascIn = VECS[i].casc;
      #5;
      chk($sformatf("R1 R2 R4 vec%0d combOut", i), combOut, VECS[i].expComb);
      chk($sformatf("R1 R4 vec%0d carryOut", i), carryOut, VECS[i].expCarry);
      chk($sformatf("R3 vec%0d cascOut", i), cascOut, VECS[i].expCasc);
      chk($sformatf("R10 vec%0d regOut held", i), regOut, 1'b0);
    end

    // R5 normal capture
    @(negedge clk);
    cfgMode = 2'd0; cfgMask = 16'h6996; cfgUseCin = 0; cfgPack = 0;
    dataIn = 4'b0001; carryIn = 0; cascIn = 1; clkEn = 1;
    edgeThen();
    chk("R5 normal regOut", regOut, 1'b1);
    chk("R5 normal combOut", combOut, 1'b1);

    // R9 clear
    @(negedge clk); sClr = 1;
    edgeThen();
    chk("R9 clear", regOut, 1'b0);

    // R6 packed register
    @(negedge clk); sClr = 0; cfgPack = 1; cfgUseCin = 1; dataIn = 4'b1000; carryIn = 0;
    edgeThen();
    chk("R6 packed regOut", regOut, 1'b1);
    chk("R6 packed combOut", combOut, 1'b0);

    // R10 hold with clear/load asserted
    @(negedge clk); cfgPack = 0; cfgUseCin = 0; clkEn = 0; sClr = 1; sLoad = 1; dataIn = 4'b0000;
    edgeThen();
    chk("R10 hold", regOut, 1'b1);

    // R9 clear beats load
    @(negedge clk); clkEn = 1; dataIn = 4'b0100;
    edgeThen();
    chk("R9 clear over load", regOut, 1'b0);

    // R9 load beats LUT
    @(negedge clk); sClr = 0; cfgMask = 16'h0000;
    edgeThen();
    chk("R9 load over lut", regOut, 1'b1);

    // R5 arithmetic: sum 0 carry 1 for d0=1 d1=1 cin=0
    @(negedge clk); sLoad = 0; cfgMode = 2'd1; cfgMask = 16'hE896;
    dataIn = 4'b0011; carryIn = 0; clkEn = 0;
    #5;
    chk("R4 arith carryOut", carryOut, 1'b1);
    chk("R3 arith cascOut", cascOut, 1'b0);
    @(negedge clk); clkEn = 1;
    edgeThen();
    chk("R5 arith regOut", regOut, 1'b0);
    chk("R5 arith combOut", combOut, 1'b0);

    // R7 counter up toggle
    @(negedge clk); cfgMode = 2'd2; dataIn = 4'b0011; carryIn = 1; clkEn = 0;
    #5;
    chk("R8 up q0 carryOut", carryOut, 1'b0);
    @(negedge clk); clkEn = 1;
    edgeThen();
    chk("R7 up toggle", regOut, 1'b1);
    chk("R7 combOut follows", combOut, 1'b1);
    chk("R8 up q1 carryOut", carryOut, 1'b1);

    // R8 down direction, R3 in counter mode
    @(negedge clk); clkEn = 0; dataIn = 4'b0001;
    #5;
    chk("R8 down q1 carryOut", carryOut, 1'b0);
    chk("R3 counter cascOut", cascOut, 1'b1);
    @(negedge clk); cascIn = 0;
    #5;
    chk("R3 counter casc low", cascOut, 1'b0);

    // R7 no toggle without carry or enable
    @(negedge clk); cascIn = 1; clkEn = 1; dataIn = 4'b0011; carryIn = 0;
    edgeThen();
    chk("R7 no carry hold", regOut, 1'b1);
    @(negedge clk); dataIn = 4'b0010; carryIn = 1;
    edgeThen();
    chk("R7 no enable hold", regOut, 1'b1);

    // R7 down toggle, then R8 down carry with q=0
    @(negedge clk); dataIn = 4'b0001; carryIn = 1;
    edgeThen();
    chk("R7 down toggle", regOut, 1'b0);
    chk("R8 down q0 carryOut", carryOut, 1'b1);

    // R9 load and clear in counter mode
    @(negedge clk); dataIn = 4'b0100; sLoad = 1;
    edgeThen();
    chk("R9 counter load", regOut, 1'b1);
    @(negedge clk); dataIn = 4'b0011; sLoad = 0; sClr = 1;
    edgeThen();
    chk("R9 counter clear", regOut, 1'b0);

    // R11 asynchronous reset between edges
    @(negedge clk); sClr = 0; sLoad = 1; dataIn = 4'b0100;
    edgeThen();
    chk("R9 reload before reset", regOut, 1'b1);
    @(negedge clk); clkEn = 0; sLoad = 0;
    rstN = 0;
    #1;
    chk("R11 async reset", regOut, 1'b0);
    @(negedge clk); rstN = 1;
    edgeThen();
    chk("R11 stays clear", regOut, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule